// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block turns single-word read and write requests, each carrying one flat address, into the pin sequence of a dynamic memory whose address pins are shared between a row phase and a column phase. The row part of the address goes out first under the row strobe. The column part follows under the column strobe, together with write enable for a store or output enable for a load. Data travels over one bidirectional data path.

After an access the row stays open and the sequencer remembers which row it is. A later request to that row skips the row phase and strobes only a new column. A request to a different row first closes the open row with a precharge. The block also generates its own refresh traffic. A programmable interval timer raises a refresh request, and each refresh strobes one whole row with no column phase. A row counter steps through every row in order.

Requests use a valid/ready handshake. Read data comes back with a one-cycle response strobe.

Top module: `mxdram_seq`

## Requirements
- R1: The flat address splits as row = `req_addr[21:11]` and column = `req_addr[10:0]`. The row value is on `mem_addr` when `mem_ras` rises, and the column value is on `mem_addr` when `mem_cas` rises. `mem_addr` holds steady while `mem_ras` stays high without `mem_cas`.
- R2: `mem_cas` is high only while `mem_ras` is high, and never rises in the same cycle as `mem_ras`.
- R3: After a read or write completes, `mem_ras` stays high (the row is left open) until a miss or a refresh closes it.
- R4: A request to the open row produces no new rise of `mem_ras`. A request to any other row, or one issued while no row is open, produces exactly one rise of `mem_ras`.
- R5: For a write, `mem_we` is high for the whole column phase and the block drives `req_wdata` onto `mem_dq`. For a read, `mem_oe` is high for the whole column phase and the block does not drive `mem_dq`. `mem_we` and `mem_oe` are never high together, and neither is high outside the column phase.
- R6: A refresh is a `mem_ras` pulse with no `mem_cas`. Refreshes present rows 0, 1, 2 and onward in order, and wrap from 2047 back to 0.
- R7: With `refi` = N > 0, refreshes are requested every N cycles. `refi` = 0 disables refresh. An open row is precharged before a refresh starts.
- R8: While a refresh is pending, `req_ready` is low. A request held during that time is served after the refresh, and then as a row miss.
- R9: Phase lengths in cycles are: row setup `T_SETUP` (strobes low, row on the bus), row strobe `T_RAS` before `mem_cas` rises, column strobe exactly `T_CAS`, and precharge at least `T_PRE` with `mem_ras` low.
- R10: Reset deasserts all strobes, closes any open row, and clears the refresh row counter and the interval timer. The first refresh after reset uses row 0.
- R11: A request is taken in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only when the sequencer is idle. For each read, `rsp_valid` pulses once, in the cycle after the column phase, with the stored data on `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| refi | input | 16 | Refresh interval in cycles, 0 disables refresh |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Flat word address, row in upper bits |
| req_wdata | input | 1 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 1 | Read data |
| mem_addr | output | 11 | Shared row/column address bus |
| mem_ras | output | 1 | Row strobe, active high |
| mem_cas | output | 1 | Column strobe, active high |
| mem_we | output | 1 | Write enable, active high |
| mem_oe | output | 1 | Output enable, active high |
| mem_dq | inout | 1 | Bidirectional data |

## Verification
A refresh request from the interval timer can arrive while a host request is already waiting. To provoke this, the bench programs a two-cycle interval just after a row-miss write has been accepted, so the refresh becomes pending in the middle of that access. The bench then holds a read to the same row at the request port. The outcome is judged at the pins: a column-less row pulse must come between the two accesses, the read must show a fresh row phase because the page was closed, and the returned data must match what was written.

// File: rtl/mxdram_pkg.sv
package mxdram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RSET,
    ST_RAS,
    ST_CAS,
    ST_RPRE
  } seq_st_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/mxdram_phase.sv
module mxdram_phase #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/mxdram_refresh.sv
module mxdram_refresh #(
  parameter int ROW_W  = 11,
  parameter int REFI_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REFI_W-1:0] refi,
  input  logic              ref_done,
  output logic              ref_pend,
  output logic [ROW_W-1:0]  ref_row
);
  logic [REFI_W-1:0] timer;
  logic              tick;

  function automatic logic interval_hit(input logic [REFI_W-1:0] t,
                                        input logic [REFI_W-1:0] n);
    return (n != '0) && (t >= n - 1'b1);
  endfunction

  assign tick = interval_hit(timer, refi);

  always_ff @(posedge clk) begin
    if (rst) begin
      timer    <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      if (refi == '0 || tick) timer <= '0;
      else                    timer <= timer + 1'b1;
      ref_pend <= tick | (ref_pend & ~ref_done);
      if (ref_done) ref_row <= ref_row + 1'b1;
    end
  end
endmodule

// File: rtl/mxdram_page.sv
module mxdram_page #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_set,
  input  logic [ROW_W-1:0] set_row,
  input  logic             close,
  input  logic [ROW_W-1:0] req_row,
  output logic             row_open,
  output logic [ROW_W-1:0] open_row,
  output logic             hit
);
  function automatic logic same_row(input logic is_open,
                                    input logic [ROW_W-1:0] a,
                                    input logic [ROW_W-1:0] b);
    return is_open && (a == b);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      row_open <= 1'b0;
      open_row <= '0;
    end else if (close) begin
      row_open <= 1'b0;
    end else if (open_set) begin
      row_open <= 1'b1;
      open_row <= set_row;
    end
  end

  assign hit = same_row(row_open, open_row, req_row);
endmodule

// File: rtl/mxdram_seq.sv
module mxdram_seq
  import mxdram_pkg::*;
#(
  parameter int ROW_W   = 11,
  parameter int COL_W   = 11,
  parameter int DATA_W  = 1,
  parameter int REFI_W  = 16,
  parameter int T_SETUP = 1,
  parameter int T_RAS   = 2,
  parameter int T_CAS   = 2,
  parameter int T_PRE   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [REFI_W-1:0]        refi,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
  output logic                     mem_ras,
  output logic                     mem_cas,
  output logic                     mem_we,
  output logic                     mem_oe,
  inout  wire  [DATA_W-1:0]        mem_dq
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TMAX   = max4(T_SETUP, T_RAS, T_CAS, T_PRE);
  localparam int CNT_W  = (TMAX > 1) ? $clog2(TMAX) : 1;

  initial begin
    if (T_CAS < 2) $error("T_CAS must be at least 2 so read data settles");
    if (T_SETUP < 1 || T_RAS < 1 || T_PRE < 1) $error("phase lengths must be at least 1");
  end

  function automatic logic [ROW_W-1:0] addr_row(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] addr_col(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] phase_ld(input int t);
    return CNT_W'(t - 1);
  endfunction

  seq_st_t st, st_n;

  logic              ph_load, ph_last;
  logic [CNT_W-1:0]  ph_val;
  logic              accept, ref_done, open_set, close_row, cap_rd;
  logic              ref_pend;
  logic [ROW_W-1:0]  ref_row;
  logic              row_open, page_hit;
  logic [ROW_W-1:0]  open_row;
  logic              job_ref;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              wr_q;
  logic [DATA_W-1:0] wd_q;
  logic [ROW_W-1:0]  tgt_row;
  logic              dq_drive;

  mxdram_phase #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .load_val (ph_val),
    .last     (ph_last)
  );

  mxdram_refresh #(.ROW_W(ROW_W), .REFI_W(REFI_W)) u_refresh (
    .clk      (clk),
    .rst      (rst),
    .refi     (refi),
    .ref_done (ref_done),
    .ref_pend (ref_pend),
    .ref_row  (ref_row)
  );

  mxdram_page #(.ROW_W(ROW_W)) u_page (
    .clk      (clk),
    .rst      (rst),
    .open_set (open_set),
    .set_row  (row_q),
    .close    (close_row),
    .req_row  (addr_row(req_addr)),
    .row_open (row_open),
    .open_row (open_row),
    .hit      (page_hit)
  );

  always_comb begin
    st_n      = st;
    ph_load   = 1'b0;
    ph_val    = '0;
    accept    = 1'b0;
    ref_done  = 1'b0;
    open_set  = 1'b0;
    close_row = 1'b0;
    cap_rd    = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (ref_pend) begin
          if (row_open) begin
            st_n = ST_PRE;  ph_load = 1'b1; ph_val = phase_ld(T_PRE); close_row = 1'b1;
          end else begin
            st_n = ST_RSET; ph_load = 1'b1; ph_val = phase_ld(T_SETUP);
          end
        end else if (req_valid) begin
          accept = 1'b1;
          if (page_hit) begin
            st_n = ST_CAS;  ph_load = 1'b1; ph_val = phase_ld(T_CAS);
          end else if (row_open) begin
            st_n = ST_PRE;  ph_load = 1'b1; ph_val = phase_ld(T_PRE); close_row = 1'b1;
          end else begin
            st_n = ST_RSET; ph_load = 1'b1; ph_val = phase_ld(T_SETUP);
          end
        end
      end
      ST_PRE: if (ph_last) begin
        st_n = ST_RSET; ph_load = 1'b1; ph_val = phase_ld(T_SETUP);
      end
      ST_RSET: if (ph_last) begin
        st_n = ST_RAS; ph_load = 1'b1; ph_val = phase_ld(T_RAS);
      end
      ST_RAS: if (ph_last) begin
        if (job_ref) begin
          st_n = ST_RPRE; ph_load = 1'b1; ph_val = phase_ld(T_PRE); ref_done = 1'b1;
        end else begin
          st_n = ST_CAS; ph_load = 1'b1; ph_val = phase_ld(T_CAS); open_set = 1'b1;
        end
      end
      ST_CAS: if (ph_last) begin
        st_n = ST_IDLE; cap_rd = ~wr_q;
      end
      ST_RPRE: if (ph_last) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      job_ref   <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st        <= st_n;
      rsp_valid <= cap_rd;
      if (cap_rd) rsp_rdata <= mem_dq;
      if (st == ST_IDLE && ref_pend) job_ref <= 1'b1;
      if (accept) begin
        job_ref <= 1'b0;
        row_q   <= addr_row(req_addr);
        col_q   <= addr_col(req_addr);
        wr_q    <= req_write;
        wd_q    <= req_wdata;
      end
    end
  end

  assign req_ready = (st == ST_IDLE) && !ref_pend;
  assign tgt_row   = job_ref ? ref_row : row_q;

  always_comb begin
    unique case (st)
      ST_RSET, ST_RAS: mem_addr = BUS_W'(tgt_row);
      ST_CAS:          mem_addr = BUS_W'(col_q);
      ST_IDLE:         mem_addr = row_open ? BUS_W'(open_row) : '0;
      default:         mem_addr = '0;
    endcase
  end

  assign mem_ras  = (st == ST_RAS) || (st == ST_CAS) || (st == ST_IDLE && row_open);
  assign mem_cas  = (st == ST_CAS);
  assign mem_we   = (st == ST_CAS) && wr_q;
  assign mem_oe   = (st == ST_CAS) && !wr_q;
  assign dq_drive = mem_we;
  assign mem_dq   = dq_drive ? wd_q : 'z;
endmodule

// File: rtl/mxdram_seq_chk.sv
module mxdram_seq_chk #(
  parameter int ROW_W  = 11,
  parameter int BUS_W  = 11,
  parameter int T_RAS  = 2,
  parameter int T_CAS  = 2,
  parameter int T_PRE  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_ras,
  input logic             mem_cas,
  input logic             mem_we,
  input logic             mem_oe,
  input logic [BUS_W-1:0] mem_addr,
  input logic             req_ready,
  input logic             ref_pend,
  input logic [ROW_W-1:0] ref_row
);
  logic [7:0] cas_run, ras_run, low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_run <= '0;
      ras_run <= '0;
      low_run <= 8'hff;
    end else begin
      cas_run <= mem_cas ? ((cas_run == 8'hff) ? cas_run : cas_run + 1'b1) : '0;
      ras_run <= mem_ras ? ((ras_run == 8'hff) ? ras_run : ras_run + 1'b1) : '0;
      low_run <= !mem_ras ? ((low_run == 8'hff) ? low_run : low_run + 1'b1) : '0;
    end
  end

  // R2
  p_cas_in_row_r2: assert property (@(posedge clk) disable iff (rst)
    mem_cas |-> mem_ras);
  p_cas_after_row_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_cas) |-> $past(mem_ras));
  // R5
  p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_oe));
  p_dir_in_col_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_oe) |-> mem_cas);
  // R8
  p_ready_blocked_r8: assert property (@(posedge clk) disable iff (rst)
    ref_pend |-> !req_ready);
  // R6
  p_ref_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ref_row != $past(ref_row)) |-> ref_row == ROW_W'($past(ref_row) + 1'b1));
  // R9
  p_cas_len_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_cas) |-> cas_run == 8'(T_CAS));
  p_ras_len_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_cas) |-> ras_run >= 8'(T_RAS));
  p_pre_len_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ras) |-> low_run >= 8'(T_PRE));
  // R1
  p_addr_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (mem_ras && $past(mem_ras) && !mem_cas && !$past(mem_cas)) |-> $stable(mem_addr));
  // R10
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_ras && !mem_cas && !ref_pend));
endmodule

bind mxdram_seq mxdram_seq_chk #(
  .ROW_W (ROW_W),
  .BUS_W (BUS_W),
  .T_RAS (T_RAS),
  .T_CAS (T_CAS),
  .T_PRE (T_PRE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_ras   (mem_ras),
  .mem_cas   (mem_cas),
  .mem_we    (mem_we),
  .mem_oe    (mem_oe),
  .mem_addr  (mem_addr),
  .req_ready (req_ready),
  .ref_pend  (ref_pend),
  .ref_row   (ref_row)
);

// File: tb/mxdram_seq_tb.sv
module mxdram_seq_tb;
  localparam int RW = 11;
  localparam int CW = 11;
  localparam int AW = RW + CW;
  localparam int DW = 1;
  localparam int T_CAS = 2;
  localparam int T_RAS = 2;
  localparam int T_PRE = 2;
  localparam int VW = 1 + AW + DW + 1;
  localparam int NV = 11;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic [15:0]   refi = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [RW-1:0] mem_addr;
  logic          mem_ras, mem_cas, mem_we, mem_oe;
  wire  [DW-1:0] dq;

  mxdram_seq u_dut (
    .clk(clk), .rst(rst), .refi(refi),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ras(mem_ras), .mem_cas(mem_cas),
    .mem_we(mem_we), .mem_oe(mem_oe), .mem_dq(dq)
  );

  // memory model: row latched on row strobe rise, column on column strobe rise
  logic [DW-1:0] store [logic [AW-1:0]];
  logic [RW-1:0] m_row = '0;
  logic [DW-1:0] m_q = '0;
  logic          m_ras_q = 1'b0, m_cas_q = 1'b0;
  assign dq = mem_oe ? m_q : 'z;

  always @(posedge clk) begin
    m_ras_q <= mem_ras;
    m_cas_q <= mem_cas;
    if (mem_ras && !m_ras_q) m_row <= mem_addr;
    if (mem_cas && !m_cas_q) begin
      if (mem_we) store[{m_row, mem_addr}] = dq;
      else if (store.exists({m_row, mem_addr})) m_q <= store[{m_row, mem_addr}];
      else m_q <= '0;
    end
  end

  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pin monitor, sampled 2 ns after each rising edge
  int ras_rises = 0, ref_events = 0, ref_at_cas = 0;
  logic [RW-1:0] rise_addr = '0, cas_addr = '0, exp_ref = '0;
  bit p_ras = 0, p_cas = 0, cas_seen = 0, chk_period = 0, have_prev = 0;
  int cas_run = 0, ras_run = 0, low_run = 1000, rise_cyc = 0, prev_ref_rise = 0;

  always @(posedge clk) begin
    #2;
    cyc++;
    if (rst) begin
      p_ras = 0; p_cas = 0; exp_ref = '0; have_prev = 0;
      cas_run = 0; ras_run = 0; low_run = 1000;
    end else begin
      if (mem_ras && !p_ras) begin
        ras_rises++;
        rise_addr = mem_addr;
        cas_seen = 0;
        rise_cyc = cyc;
        chk(low_run >= T_PRE, "R9 precharge length", low_run, T_PRE);
      end
      if (mem_cas && !p_cas) begin
        cas_addr = mem_addr;
        cas_seen = 1;
        ref_at_cas = ref_events;
        chk(ras_run >= T_RAS, "R2 row phase before column", ras_run, T_RAS);
      end
      if (!mem_cas && p_cas)
        chk(cas_run == T_CAS, "R9 column strobe length", cas_run, T_CAS);
      if (!mem_ras && p_ras && !cas_seen) begin
        chk(rise_addr == exp_ref, "R6 refresh row order", rise_addr, exp_ref);
        if (chk_period && have_prev)
          chk(rise_cyc - prev_ref_rise == int'(refi), "R7 refresh interval",
              rise_cyc - prev_ref_rise, int'(refi));
        have_prev = 1;
        prev_ref_rise = rise_cyc;
        exp_ref = exp_ref + 1'b1;
        ref_events++;
      end
      cas_run = mem_cas ? cas_run + 1 : 0;
      ras_run = mem_ras ? ras_run + 1 : 0;
      low_run = !mem_ras ? low_run + 1 : 0;
      p_ras = mem_ras;
      p_cas = mem_cas;
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [VW-1:0] mk(input bit we, input logic [RW-1:0] r,
                                       input logic [CW-1:0] c, input bit d, input bit h);
    return {we, r, c, DW'(d), h};
  endfunction

  // {write, row, col, data, expected page hit}
  localparam logic [VW-1:0] VECS [NV] = '{
    mk(1, 11'd0,    11'd0,    1, 0),
    mk(1, 11'd0,    11'd2047, 1, 1),
    mk(0, 11'd0,    11'd0,    0, 1),
    mk(1, 11'd2047, 11'd5,    1, 0),
    mk(0, 11'd2047, 11'd5,    0, 1),
    mk(0, 11'd0,    11'd2047, 0, 0),
    mk(1, 11'd0,    11'd2047, 0, 1),
    mk(0, 11'd0,    11'd2047, 0, 1),
    mk(0, 11'd1,    11'd0,    0, 0),
    mk(1, 11'd1024, 11'd1024, 1, 0),
    mk(0, 11'd1024, 11'd1024, 0, 1)
  };

  logic [DW-1:0] shadow [logic [AW-1:0]];

  function automatic int exp_data(input logic [AW-1:0] a);
    if (shadow.exists(a)) return int'(shadow[a]);
    return 0;
  endfunction

  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_req(input bit we, output logic [DW-1:0] rd);
    rd = '0;
    if (!we) begin
      while (!rsp_valid) @(negedge clk);
      rd = rsp_rdata;
    end else begin
      while (!req_ready) @(negedge clk);
    end
  endtask

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit exp_hit, input string tag);
    int r0;
    logic [DW-1:0] rd;
    r0 = ras_rises;
    issue(we, a, d);
    finish_req(we, rd);
    @(negedge clk);
    chk(ras_rises - r0 == (exp_hit ? 0 : 1), {"R4 row phase count ", tag},
        ras_rises - r0, exp_hit ? 0 : 1);
    chk(cas_addr == a[CW-1:0], {"R1 column on bus ", tag}, cas_addr, a[CW-1:0]);
    if (!exp_hit)
      chk(rise_addr == a[AW-1:CW], {"R1 row on bus ", tag}, rise_addr, a[AW-1:CW]);
    if (we) shadow[a] = d;
    else chk(int'(rd) == exp_data(a), {"R11 read data ", tag}, rd, exp_data(a));
    chk(mem_ras == 1'b1, {"R3 row left open ", tag}, mem_ras, 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!mem_ras && !mem_cas && !mem_we && !mem_oe, "R10 strobes low after reset",
        {mem_ras, mem_cas, mem_we, mem_oe}, 0);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R10 idle after reset",
        {req_ready, rsp_valid}, 2);
  endtask

  initial begin
    int r0, e0;
    logic [DW-1:0] rd;
    do_reset();

    // vector table walk, refresh disabled
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      access(v[VW-1], v[VW-2 -: AW], v[1 +: DW], v[0], $sformatf("vec%0d", i));
    end

    // reset with a row open: page closed, next access is a miss, data kept
    do_reset();
    access(0, {11'd1024, 11'd1024}, '0, 0, "R10 miss after reset");

    // refresh collides with a waiting request
    do_reset();
    r0 = ras_rises; e0 = ref_events;
    issue(1, {11'd3, 11'd9}, 1'b1);
    refi = 16'd2;
    req_valid = 1; req_write = 0; req_addr = {11'd3, 11'd9};
    @(negedge clk); @(negedge clk);
    refi = '0;
    shadow[{11'd3, 11'd9}] = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    finish_req(0, rd);
    @(negedge clk);
    chk(ref_events - e0 == 1, "R8 one refresh between accesses", ref_events - e0, 1);
    chk(ref_at_cas == e0 + 1, "R8 refresh served before held request", ref_at_cas, e0 + 1);
    chk(ras_rises - r0 == 3, "R7 open row closed for refresh, held read misses",
        ras_rises - r0, 3);
    chk(rd == 1'b1, "R11 held read data", rd, 1);

    // full refresh sweep with wrap, interval checked
    do_reset();
    e0 = ref_events;
    chk(ref_events - e0 == 0, "R7 no refresh while disabled", ref_events - e0, 0);
    chk_period = 1;
    refi = 16'd12;
    while (ref_events - e0 < 2050) @(negedge clk);
    refi = '0;
    chk_period = 0;
    chk(exp_ref == 11'd2, "R6 refresh row counter wrapped", exp_ref, 2);
    repeat (40) @(negedge clk);
    e0 = ref_events;
    repeat (40) @(negedge clk);
    chk(ref_events == e0, "R7 interval zero stops refresh", ref_events - e0, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule